// File: doc/BRIEF.md
# System Power and Clock-Gating Controller

This block is the power-management core of a small peripheral device. It keeps two writable control registers and two fixed identification registers behind a simple register bus: single-cycle writes and a read port that follows the address combinationally. It produces a clock-enable output for each of three function units, an external-clock select, an oscillator-off (hibernate) request, an IO-supply-off flag, a one-clock soft-reset pulse and a sleep-mode output.

Sleep is entered in one of two ways. Software can issue a one-shot sleep command. An auto-sleep timer can also count millisecond ticks while nothing happens. The idle delay is picked by a 3-bit code. An activity pulse from anywhere in the system ends sleep and restarts the idle count from zero.

Top module: `sys_pwr_ctrl`

## Requirements
- R1: After reset the control register (address 0x02) reads 0x0F and the second control register (address 0x03) reads 0x00. All three clock enables are 1. Sleep, hibernate, external-clock select, IO-supply-off and the soft-reset pulse are 0.
- R2: Address 0x80 reads 0x02 and address 0x81 reads 0x12. Writes to these addresses change nothing. Any unmapped address reads 0x00.
- R3: In the control register, bit 6 drives the external-clock select, bit 5 drives the hibernate request, bit 3 drives the GPIO clock enable, bit 1 drives the keypad clock enable and bit 0 drives the PWM clock enable. Bit 2 always reads 1 and cannot be written.
- R4: Writing the control register with bit 7 set raises the soft-reset pulse for exactly one clock, in the cycle after the write. In that same cycle every register holds its R1 value. Bit 7 reads 1 only during the pulse.
- R5: Writing the control register with bit 4 set puts the block into sleep at the next clock. A sleep command wins over activity in the same cycle. Bit 4 always reads 0.
- R6: In the second control register, bit 4 drives the IO-supply-off flag, bit 3 enables auto-sleep and bits 2:0 hold the delay code. Bits 7:5 always read 0.
- R7: With auto-sleep enabled and the block awake, delay code 0 puts the block to sleep on the 4th clock that carries a ms tick. Code n (1 to 7) does so on tick 8·2^n, giving 16, 32, 64, 128, 256, 512 and 1024.
- R8: An activity pulse while awake resets the idle count to zero.
- R9: An activity pulse while asleep clears sleep at the next clock, and the idle count restarts from zero.
- R10: With auto-sleep disabled, ms ticks never cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| activity | input | 1 | Wake / idle-restart pulse |
| soft_rst_pulse | output | 1 | One-clock soft reset |
| clk_en_gpio | output | 1 | GPIO unit clock enable |
| clk_en_keypad | output | 1 | Keypad unit clock enable |
| clk_en_pwm | output | 1 | PWM unit clock enable |
| ext_clk_sel | output | 1 | Select external 32 kHz clock |
| hibernate_req | output | 1 | Oscillator-off request |
| io_supply_off | output | 1 | IO supply about to be removed |
| sleep_mode | output | 1 | Device is asleep |

## Verification
The bench counts exact tick edges for delay codes 0, 1 and 7. An off-by-one compare would put the block to sleep one tick early or late, and a wrong shift would miss 1024 entirely. It places an activity pulse partway through a count. A design that fails to clear the counter would then sleep after the remaining ticks instead of a full period. It also checks that the soft-reset bit is visible for exactly one cycle and then clears, and that every register is back at its default; a sticky bit would repeat the reset. Finally it checks that writes to the read-only IDs and to the reserved bits leave readback unchanged.

// File: rtl/sys_pwr_ctrl.sv
module sys_pwr_ctrl #(
  parameter int          AW       = 8,
  parameter int          CNT_W    = 11,
  parameter logic [7:0]  CHIP_VAL = 8'h02,
  parameter logic [7:0]  VER_VAL  = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ms_tick,
  input  logic          activity,
  output logic          soft_rst_pulse,
  output logic          clk_en_gpio,
  output logic          clk_en_keypad,
  output logic          clk_en_pwm,
  output logic          ext_clk_sel,
  output logic          hibernate_req,
  output logic          io_supply_off,
  output logic          sleep_mode
);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h02);
  localparam logic [AW-1:0] A_CTRL2 = AW'(8'h03);
  localparam logic [AW-1:0] A_CHIP  = AW'(8'h80);
  localparam logic [AW-1:0] A_VER   = AW'(8'h81);

  logic [4:0]       mode_q;
  logic [4:0]       pm_q;
  logic [CNT_W-1:0] idle_q;
  logic [CNT_W-1:0] idle_nx;
  logic [CNT_W-1:0] limit;

  wire wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  wire wr_ctrl2  = bus_wr && (bus_addr == A_CTRL2);
  wire do_reset  = wr_ctrl && bus_wdata[7];
  wire do_sleep  = wr_ctrl && bus_wdata[4];
  wire auto_en   = pm_q[3];

  assign idle_nx = idle_q + CNT_W'(1);
  assign limit   = (pm_q[2:0] == 3'd0) ? CNT_W'(4) : (CNT_W'(8) << pm_q[2:0]);

  assign ext_clk_sel   = mode_q[4];
  assign hibernate_req = mode_q[3];
  assign clk_en_gpio   = mode_q[2];
  assign clk_en_keypad = mode_q[1];
  assign clk_en_pwm    = mode_q[0];
  assign io_supply_off = pm_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q         <= 5'b00111;
      pm_q           <= '0;
      idle_q         <= '0;
      sleep_mode     <= 1'b0;
      soft_rst_pulse <= 1'b0;
    end else if (do_reset) begin
      mode_q         <= 5'b00111;
      pm_q           <= '0;
      idle_q         <= '0;
      sleep_mode     <= 1'b0;
      soft_rst_pulse <= 1'b1;
    end else begin
      soft_rst_pulse <= 1'b0;
      if (wr_ctrl)  mode_q <= {bus_wdata[6:5], bus_wdata[3], bus_wdata[1:0]};
      if (wr_ctrl2) pm_q   <= bus_wdata[4:0];
      if (do_sleep) begin
        sleep_mode <= 1'b1;
        idle_q     <= '0;
      end else if (activity) begin
        sleep_mode <= 1'b0;
        idle_q     <= '0;
      end else if (!auto_en || sleep_mode) begin
        idle_q <= '0;
      end else if (ms_tick) begin
        if (idle_nx >= limit) begin
          sleep_mode <= 1'b1;
          idle_q     <= '0;
        end else begin
          idle_q <= idle_nx;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {soft_rst_pulse, mode_q[4:3], 1'b0, mode_q[2], 1'b1, mode_q[1:0]};
      A_CTRL2: bus_rdata = {3'b000, pm_q};
      A_CHIP:  bus_rdata = CHIP_VAL;
      A_VER:   bus_rdata = VER_VAL;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sys_pwr_ctrl_chk.sv
module sys_pwr_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          activity,
  input logic          soft_rst_pulse,
  input logic          clk_en_gpio,
  input logic          clk_en_keypad,
  input logic          clk_en_pwm,
  input logic          ext_clk_sel,
  input logic          hibernate_req,
  input logic          io_supply_off,
  input logic          sleep_mode
);
  wire ctl_wr  = bus_wr && (bus_addr == AW'(8'h02));
  wire rst_wr  = ctl_wr && bus_wdata[7];
  wire slp_wr  = ctl_wr && bus_wdata[4];

  a_r4_write_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> soft_rst_pulse);

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse && !rst_wr |=> !soft_rst_pulse);

  a_r4_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> clk_en_gpio && clk_en_keypad && clk_en_pwm &&
                       !ext_clk_sel && !hibernate_req && !io_supply_off && !sleep_mode);

  a_r5_sleep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    slp_wr && !rst_wr |=> sleep_mode);

  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    activity && !slp_wr |=> !sleep_mode);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(8'h03)) |-> (bus_rdata[7:5] == 3'b000));
endmodule

bind sys_pwr_ctrl sys_pwr_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .activity(activity),
  .soft_rst_pulse(soft_rst_pulse), .clk_en_gpio(clk_en_gpio),
  .clk_en_keypad(clk_en_keypad), .clk_en_pwm(clk_en_pwm),
  .ext_clk_sel(ext_clk_sel), .hibernate_req(hibernate_req),
  .io_supply_off(io_supply_off), .sleep_mode(sleep_mode)
);

// File: tb/sys_pwr_ctrl_test.sv
module sys_pwr_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ms_tick = 1'b0;
  logic       activity = 1'b0;
  logic       soft_rst_pulse, clk_en_gpio, clk_en_keypad, clk_en_pwm;
  logic       ext_clk_sel, hibernate_req, io_supply_off, sleep_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_pwr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ms_tick(ms_tick),
    .activity(activity), .soft_rst_pulse(soft_rst_pulse),
    .clk_en_gpio(clk_en_gpio), .clk_en_keypad(clk_en_keypad),
    .clk_en_pwm(clk_en_pwm), .ext_clk_sel(ext_clk_sel),
    .hibernate_req(hibernate_req), .io_supply_off(io_supply_off),
    .sleep_mode(sleep_mode)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_activity();
    @(negedge clk);
    activity = 1'b1;
    @(negedge clk);
    activity = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h02, d); check("R1 ctrl", d, 8'h0F);
    rd(8'h03, d); check("R1 ctrl2", d, 8'h00);
    check("R1 enables", {clk_en_gpio, clk_en_keypad, clk_en_pwm}, 3'b111);
    check("R1 flags", {sleep_mode, hibernate_req, ext_clk_sel, io_supply_off, soft_rst_pulse}, 5'b0);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    wr(8'h80, 8'hAA);
    wr(8'h81, 8'h55);
    rd(8'h80, d); check("R2 chip id", d, 8'h02);
    rd(8'h81, d); check("R2 version id", d, 8'h12);
    rd(8'h44, d); check("R2 unmapped", d, 8'h00);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] d;
    wr(8'h02, 8'h4A);
    rd(8'h02, d); check("R3 read 4A", d, 8'h4E);
    check("R3 outs 4A", {ext_clk_sel, hibernate_req, clk_en_gpio, clk_en_keypad, clk_en_pwm}, 5'b10110);
    wr(8'h02, 8'h21);
    rd(8'h02, d); check("R3 read 21", d, 8'h25);
    check("R3 outs 21", {ext_clk_sel, hibernate_req, clk_en_gpio, clk_en_keypad, clk_en_pwm}, 5'b01001);
    wr(8'h02, 8'h0F);
  endtask

  task automatic t_ctrl2();
    logic [7:0] d;
    wr(8'h03, 8'hF0);
    rd(8'h03, d); check("R6 reserved zero", d, 8'h10);
    check("R6 io off", io_supply_off, 1'b1);
    wr(8'h03, 8'h00);
    check("R6 io on", io_supply_off, 1'b0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr(8'h02, 8'h61);
    wr(8'h03, 8'h1B);
    wr(8'h02, 8'h80);
    check("R4 pulse high", soft_rst_pulse, 1'b1);
    rd(8'h02, d); check("R4 ctrl during pulse", d, 8'h8F);
    rd(8'h03, d); check("R4 ctrl2 default", d, 8'h00);
    check("R4 outs default", {clk_en_gpio, clk_en_keypad, clk_en_pwm, ext_clk_sel, hibernate_req, io_supply_off}, 6'b111000);
    @(negedge clk);
    check("R4 pulse one clock", soft_rst_pulse, 1'b0);
    rd(8'h02, d); check("R4 bit clears", d, 8'h0F);
  endtask

  task automatic t_sleep_cmd();
    logic [7:0] d;
    wr(8'h02, 8'h1F);
    check("R5 sleep entered", sleep_mode, 1'b1);
    rd(8'h02, d); check("R5 bit reads 0", d, 8'h0F);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h02; bus_wdata = 8'h1F; activity = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; activity = 1'b0;
    check("R5 command beats activity", sleep_mode, 1'b1);
    pulse_activity();
    check("R9 wake", sleep_mode, 1'b0);
  endtask

  task automatic t_delay(input logic [2:0] code);
    int lim;
    lim = (code == 3'd0) ? 4 : (8 << code);
    wr(8'h03, {5'b00001, code});
    ms_tick = 1'b1;
    repeat (lim - 1) @(negedge clk);
    check($sformatf("R7 code %0d not early", code), sleep_mode, 1'b0);
    @(negedge clk);
    check($sformatf("R7 code %0d sleeps", code), sleep_mode, 1'b1);
    ms_tick = 1'b0;
    pulse_activity();
    wr(8'h03, 8'h00);
  endtask

  task automatic t_restart();
    wr(8'h03, 8'h08);
    ms_tick = 1'b1;
    repeat (3) @(negedge clk);
    activity = 1'b1;
    @(negedge clk);
    activity = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 count cleared", sleep_mode, 1'b0);
    @(negedge clk);
    check("R8 full period", sleep_mode, 1'b1);
    activity = 1'b1;
    @(negedge clk);
    activity = 1'b0;
    check("R9 wake from auto", sleep_mode, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 restart not early", sleep_mode, 1'b0);
    @(negedge clk);
    check("R9 restart sleeps", sleep_mode, 1'b1);
    ms_tick = 1'b0;
    pulse_activity();
    wr(8'h03, 8'h00);
  endtask

  task automatic t_disabled();
    wr(8'h03, 8'h00);
    ms_tick = 1'b1;
    repeat (50) @(negedge clk);
    ms_tick = 1'b0;
    check("R10 disabled no sleep", sleep_mode, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_ctrl_bits();
    t_ctrl2();
    t_soft_reset();
    t_sleep_cmd();
    t_delay(3'd0);
    t_delay(3'd1);
    t_delay(3'd7);
    t_restart();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule